// File: doc/BRIEF.md
# Keyboard and Display Console Register Interface

This block is the register-level face of a simple console: one keyboard input channel and one display output channel, both reached through a small word-addressed register bus. Arriving key codes are latched into a data register and raise a "done" flag. A bus read of that data register consumes the character and clears the flag. The display side accepts one character per bus write into its data register. That write clears the "ready" flag. Ready comes back on its own after a fixed, parameterized number of busy cycles.

Each channel has a 16-bit status word. It holds the channel's flag, an interrupt-enable bit and a 3-bit priority. The block raises a per-channel interrupt request whenever the flag and the enable bit are both set. Alongside the request it presents the channel's priority and, for the keyboard, a 16-bit vector index. Arbitration of these requests against the running program, and the processor's interrupt entry, belong to other blocks.

Top module: `console_io_regs`

## Requirements
- R1: After reset, the keyboard status (address 0) reads 0x0000, the display status (address 3) reads 0x8000, the vector register (address 2) reads the parameter VEC_RST, and both interrupt requests are low.
- R2: A cycle with keyValid high loads keyChar into the keyboard data register (read at address 1) and sets the keyboard done flag (status bit 15) at that clock edge.
- R3: A bus read of address 1 returns the stored character and clears the done flag at the clock edge. If keyValid is high in that same cycle, the read still returns the previous character, the new character is stored, and done stays set.
- R4: A bus write to address 4 while ready (display status bit 15) is set loads dispData, pulses dispStrobe for exactly one cycle and clears ready. Ready sets again exactly BUSY_CYCLES clock edges after the write edge.
- R5: A bus write to address 4 while ready is clear is dropped. dispData keeps its value, no dispStrobe pulse occurs, and the ready return time is unchanged.
- R6: kbdIrq equals keyboard done AND keyboard status bit 14, and dispIrq equals display ready AND display status bit 14. Each request falls in the same cycle its flag clears.
- R7: A write to a status register (address 0 or 3) stores bit 14 and bits 2:0. Bit 15 and bits 13:3 of the written word are ignored, and bits 13:3 read back as 0. kbdPri and dispPri present the stored bits 2:0.
- R8: The vector register at address 2 is fully writable and readable, and its value is driven on kbdVec.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busSel | input | 1 | Bus access in this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 3 | Register word address |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data (combinational on address) |
| keyValid | input | 1 | A new key code is present this cycle |
| keyChar | input | 16 | Key code |
| dispData | output | 16 | Character last accepted for display |
| dispStrobe | output | 1 | One-cycle pulse on an accepted display write |
| kbdIrq | output | 1 | Keyboard interrupt request |
| kbdPri | output | 3 | Keyboard priority |
| kbdVec | output | 16 | Keyboard vector index |
| dispIrq | output | 1 | Display interrupt request |
| dispPri | output | 3 | Display priority |

## Verification
The two functions that can fall in one cycle are key arrival and the consuming read of the keyboard data register. The bench provokes this by raising keyValid with a second code in the very cycle it reads address 1. The read must return the first code, and after that edge the data register must hold the second code with done still set. A second overlap, a display write issued while the channel is busy, is judged by an unchanged dispData, an unchanged strobe count and an unchanged ready return time.

// File: rtl/cio_pkg.sv
package cio_pkg;
  localparam int WORD_W   = 16;
  localparam int ADDR_W   = 3;
  localparam int PRI_W    = 3;
  localparam int FLAG_BIT = 15;
  localparam int IE_BIT   = 14;

  localparam logic [ADDR_W-1:0] A_KSTAT = 3'd0;
  localparam logic [ADDR_W-1:0] A_KDATA = 3'd1;
  localparam logic [ADDR_W-1:0] A_KVEC  = 3'd2;
  localparam logic [ADDR_W-1:0] A_DSTAT = 3'd3;
  localparam logic [ADDR_W-1:0] A_DDATA = 3'd4;

  typedef struct packed {
    logic keyLoad;
    logic kDataRd;
    logic kStatWr;
    logic kVecWr;
    logic dStatWr;
    logic dDataWr;
  } strobes_t;
endpackage

// File: rtl/cio_ctrl.sv
module cio_ctrl
  import cio_pkg::*;
#(
  parameter int BUSY_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              keyValid,
  output strobes_t          stb,
  output logic              kbdDone,
  output logic              dispReady
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  logic [CNT_W-1:0] busyCnt;
  logic             wrHit;
  logic             rdHit;

  assign wrHit = busSel && busWr;
  assign rdHit = busSel && !busWr;

  always_comb begin
    stb         = '0;
    stb.keyLoad = keyValid;
    stb.kDataRd = rdHit && (busAddr == A_KDATA);
    stb.kStatWr = wrHit && (busAddr == A_KSTAT);
    stb.kVecWr  = wrHit && (busAddr == A_KVEC);
    stb.dStatWr = wrHit && (busAddr == A_DSTAT);
    stb.dDataWr = wrHit && (busAddr == A_DDATA) && dispReady;
  end

  // Arrival wins over a consuming read in the same cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            kbdDone <= 1'b0;
    else if (stb.keyLoad) kbdDone <= 1'b1;
    else if (stb.kDataRd) kbdDone <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dispReady <= 1'b1;
      busyCnt   <= '0;
    end else if (stb.dDataWr) begin
      dispReady <= 1'b0;
      busyCnt   <= CNT_W'(BUSY_CYCLES);
    end else if (!dispReady) begin
      if (busyCnt == CNT_W'(1)) begin
        dispReady <= 1'b1;
        busyCnt   <= '0;
      end else begin
        busyCnt <= busyCnt - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/cio_dpath.sv
module cio_dpath
  import cio_pkg::*;
#(
  parameter logic [15:0] VEC_RST = 16'h0180
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [WORD_W-1:0] busWdata,
  input  logic [WORD_W-1:0] keyChar,
  input  logic              kbdDone,
  input  logic              dispReady,
  output logic [WORD_W-1:0] busRdata,
  output logic              kbdIe,
  output logic [PRI_W-1:0]  kbdPri,
  output logic [WORD_W-1:0] kbdVec,
  output logic              dispIe,
  output logic [PRI_W-1:0]  dispPri,
  output logic [WORD_W-1:0] dispData,
  output logic              dispStrobe
);
  logic [WORD_W-1:0] kbdData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kbdData    <= '0;
      kbdIe      <= 1'b0;
      kbdPri     <= '0;
      kbdVec     <= VEC_RST;
      dispIe     <= 1'b0;
      dispPri    <= '0;
      dispData   <= '0;
      dispStrobe <= 1'b0;
    end else begin
      dispStrobe <= stb.dDataWr;
      if (stb.keyLoad) kbdData <= keyChar;
      if (stb.kStatWr) begin
        kbdIe  <= busWdata[IE_BIT];
        kbdPri <= busWdata[PRI_W-1:0];
      end
      if (stb.dStatWr) begin
        dispIe  <= busWdata[IE_BIT];
        dispPri <= busWdata[PRI_W-1:0];
      end
      if (stb.kVecWr)  kbdVec   <= busWdata;
      if (stb.dDataWr) dispData <= busWdata;
    end
  end

  function automatic logic [WORD_W-1:0] packStat(input logic flag, input logic ie,
                                                 input logic [PRI_W-1:0] pri);
    logic [WORD_W-1:0] w;
    w = '0;
    w[FLAG_BIT]    = flag;
    w[IE_BIT]      = ie;
    w[PRI_W-1:0]   = pri;
    return w;
  endfunction

  always_comb begin
    unique case (busAddr)
      A_KSTAT: busRdata = packStat(kbdDone, kbdIe, kbdPri);
      A_KDATA: busRdata = kbdData;
      A_KVEC:  busRdata = kbdVec;
      A_DSTAT: busRdata = packStat(dispReady, dispIe, dispPri);
      default: busRdata = '0;
    endcase
  end
endmodule

// File: rtl/console_io_regs.sv
module console_io_regs
  import cio_pkg::*;
#(
  parameter int          BUSY_CYCLES = 8,
  parameter logic [15:0] VEC_RST     = 16'h0180
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busSel,
  input  logic        busWr,
  input  logic [2:0]  busAddr,
  input  logic [15:0] busWdata,
  output logic [15:0] busRdata,
  input  logic        keyValid,
  input  logic [15:0] keyChar,
  output logic [15:0] dispData,
  output logic        dispStrobe,
  output logic        kbdIrq,
  output logic [2:0]  kbdPri,
  output logic [15:0] kbdVec,
  output logic        dispIrq,
  output logic [2:0]  dispPri
);
  strobes_t stb;
  logic     kbdDone;
  logic     dispReady;
  logic     kbdIe;
  logic     dispIe;

  cio_ctrl #(.BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .keyValid(keyValid), .stb(stb), .kbdDone(kbdDone), .dispReady(dispReady)
  );

  cio_dpath #(.VEC_RST(VEC_RST)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .busAddr(busAddr), .busWdata(busWdata),
    .keyChar(keyChar), .kbdDone(kbdDone), .dispReady(dispReady),
    .busRdata(busRdata), .kbdIe(kbdIe), .kbdPri(kbdPri), .kbdVec(kbdVec),
    .dispIe(dispIe), .dispPri(dispPri), .dispData(dispData), .dispStrobe(dispStrobe)
  );

  // Requests are combinational so they drop with their flag.
  assign kbdIrq  = kbdDone && kbdIe;
  assign dispIrq = dispReady && dispIe;
endmodule

// File: rtl/cio_checker.sv
module cio_checker (
  input logic        clk,
  input logic        rstN,
  input logic        busSel,
  input logic        busWr,
  input logic [2:0]  busAddr,
  input logic        keyValid,
  input logic        kbdDone,
  input logic        kbdIrq,
  input logic        dispReady,
  input logic        dispIrq,
  input logic [15:0] dispData,
  input logic        dispStrobe
);
  logic dWrite;
  assign dWrite = busSel && busWr && (busAddr == 3'd4);

  p_done_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    keyValid |=> kbdDone);

  p_done_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWr && busAddr == 3'd1 && !keyValid) |=> !kbdDone);

  p_ready_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    (dWrite && dispReady) |=> (!dispReady && dispStrobe));

  p_strobe_busy_r4: assert property (@(posedge clk) disable iff (!rstN)
    dispStrobe |-> !dispReady);

  p_busy_drop_r5: assert property (@(posedge clk) disable iff (!rstN)
    (dWrite && !dispReady) |=> ($stable(dispData) && !dispStrobe));

  p_kirq_fall_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(kbdDone) |-> !kbdIrq);

  p_dirq_fall_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dispReady) |-> !dispIrq);

  p_flag_ro_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && busAddr == 3'd0 && !keyValid) |=> $stable(kbdDone));
endmodule

bind console_io_regs cio_checker u_chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
  .keyValid(keyValid), .kbdDone(kbdDone), .kbdIrq(kbdIrq), .dispReady(dispReady),
  .dispIrq(dispIrq), .dispData(dispData), .dispStrobe(dispStrobe)
);

// File: tb/sim_console_io_regs.sv
module sim_console_io_regs;
  localparam int          BUSY = 8;
  localparam logic [15:0] VRST = 16'h0180;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWr = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic        keyValid = 1'b0;
  logic [15:0] keyChar = '0;
  logic [15:0] dispData;
  logic        dispStrobe, kbdIrq, dispIrq;
  logic [2:0]  kbdPri, dispPri;
  logic [15:0] kbdVec;

  int checks = 0, errors = 0, strobeCnt = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  console_io_regs #(.BUSY_CYCLES(BUSY), .VEC_RST(VRST)) u0 (.*);

  always @(negedge clk) if (dispStrobe) strobeCnt++;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    busSel = 1; busWr = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 0; busWr = 0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [15:0] d);
    busAddr = a; #1 d = busRdata;
  endtask

  task automatic consumeRead(output logic [15:0] d);
    @(negedge clk);
    busSel = 1; busWr = 0; busAddr = 3'd1;
    #1 d = busRdata;
    @(negedge clk);
    busSel = 0;
  endtask

  task automatic keyIn(input logic [15:0] c);
    @(negedge clk);
    keyValid = 1; keyChar = c;
    @(negedge clk);
    keyValid = 0;
  endtask

  task automatic t_reset;
    logic [15:0] d;
    peek(3'd0, d); chk("R1 kbd status", d, 16'h0000);
    peek(3'd3, d); chk("R1 disp status", d, 16'h8000);
    peek(3'd2, d); chk("R1 vector", d, VRST);
    chk("R1 irqs", {kbdIrq, dispIrq}, 16'h0);
  endtask

  task automatic t_key_and_read;
    logic [15:0] d;
    keyIn(16'h0041);
    peek(3'd0, d); chk("R2 done set", d, 16'h8000);
    peek(3'd1, d); chk("R2 data", d, 16'h0041);
    consumeRead(d); chk("R3 read value", d, 16'h0041);
    peek(3'd0, d); chk("R3 done cleared", d, 16'h0000);
  endtask

  task automatic t_collision;
    logic [15:0] d;
    keyIn(16'h0061);
    @(negedge clk);
    busSel = 1; busWr = 0; busAddr = 3'd1; keyValid = 1; keyChar = 16'h0062;
    #1 d = busRdata;
    chk("R3 collision read returns old", d, 16'h0061);
    @(negedge clk);
    busSel = 0; keyValid = 0;
    peek(3'd1, d); chk("R3 collision new char stored", d, 16'h0062);
    peek(3'd0, d); chk("R3 collision done stays", d[15], 16'h1);
    consumeRead(d);
  endtask

  task automatic t_status_fields;
    logic [15:0] d;
    busWrite(3'd0, 16'hFFFD);
    peek(3'd0, d); chk("R7 kbd status fields", d, 16'h4005);
    chk("R7 kbdPri", kbdPri, 16'h5);
    busWrite(3'd3, 16'h3FFA);
    peek(3'd3, d); chk("R7 disp status, bit15 ignored", d, 16'h8002);
    chk("R7 dispPri", dispPri, 16'h2);
    busWrite(3'd3, 16'h0000);
    peek(3'd3, d); chk("R7 ready not writable", d, 16'h8000);
  endtask

  task automatic t_vector;
    logic [15:0] d;
    busWrite(3'd2, 16'hA5C3);
    peek(3'd2, d); chk("R8 vector read", d, 16'hA5C3);
    chk("R8 kbdVec", kbdVec, 16'hA5C3);
  endtask

  task automatic t_kirq;
    logic [15:0] d;
    busWrite(3'd0, 16'h4005);
    chk("R6 no irq without flag", kbdIrq, 1'b0);
    keyIn(16'h0031);
    chk("R6 kbd irq", kbdIrq, 1'b1);
    consumeRead(d);
    chk("R6 kbd irq drops with flag", kbdIrq, 1'b0);
    busWrite(3'd0, 16'h0005);
    keyIn(16'h0032);
    chk("R6 masked irq", kbdIrq, 1'b0);
    consumeRead(d);
  endtask

  task automatic t_display;
    logic [15:0] d;
    int s0;
    busWrite(3'd3, 16'h4001);
    chk("R6 disp irq when ready", dispIrq, 1'b1);
    s0 = strobeCnt;
    busWrite(3'd4, 16'h0048);
    chk("R4 dispData", dispData, 16'h0048);
    chk("R6 disp irq drops", dispIrq, 1'b0);
    busSel = 0; busAddr = 3'd3;
    for (int i = 1; i < BUSY; i++) begin
      if (i == 2) begin
        busSel = 1; busWr = 1; busAddr = 3'd4; busWdata = 16'h0049;
      end
      @(negedge clk);
      busSel = 0; busWr = 0; busAddr = 3'd3;
      #1 d = busRdata;
      chk("R4 busy while counting", d[15], 1'b0);
    end
    @(negedge clk);
    #1 d = busRdata;
    chk("R4 ready after BUSY cycles", d[15], 1'b1);
    chk("R4 single strobe", 16'(strobeCnt - s0), 16'd1);
    chk("R5 dropped write keeps data", dispData, 16'h0048);
    chk("R6 disp irq returns", dispIrq, 1'b1);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_key_and_read();
    t_collision();
    t_status_fields();
    t_vector();
    t_kirq();
    t_display();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule